// File: doc/BRIEF.md
# Gated Serial Result Shifter

This block sends a finished conversion result to a host over one data line, one bit for each pulse of a serial clock that the host drives. The host frames a transfer with an active-low chip select and gates the data line with an active-low read strobe. The block runs on a faster system clock. It passes the host's chip select, read, serial clock and the busy flag through synchronisers, then finds edges by comparing consecutive samples. The result word is captured when busy falls. A capture that arrives while a frame is in progress is held for the next frame, so the frame being read never changes. This lets the host read after each conversion or during the following one.

The data path has no handshake. The result is qualified by the busy falling edge, and the host paces the output with its own clock. The block cannot stall the host, and the host cannot refuse data. Back-pressure therefore does not apply. The serial clock may run continuously or in bursts, and a burst clock may rest high or low. Each case gives the same framing: sixteen bits, most significant first. Each SCLK half-period must span more than four system clocks.

Top module: `serial_result_shifter`

## Requirements
- R1: `sdout_oe_o` is 1 only while serial mode (`ser_sel_i`=1), external clock (`ext_clk_sel_i`=1), chip select low and read low all hold. While `sdout_oe_o` is 0, `sdout_o` is 0.
- R2: A chip-select falling edge in the enabled mode starts a frame. The frame shows bit 15 of the captured word on `sdout_o` before any SCLK edge.
- R3: Bits leave most significant first. A frame moves to the next bit only on an SCLK falling edge that comes after at least one SCLK rising edge in the same frame. Each bit is therefore stable across the next rising edge.
- R4: An SCLK that rests low and an SCLK that rests high at chip-select fall both deliver all 16 bits in the same order. When it rests high, the first falling edge does not advance the frame.
- R5: SCLK edges while chip select is high are ignored, and the next frame starts at bit 15.
- R6: Every chip-select falling edge restarts from bit 15, including after a frame that was cut short.
- R7: After 16 bits have been sent, `sdout_o` stays 0 through further SCLK pulses until chip select rises. `sdout_oe_o` stays 1 during that time.
- R8: `result_i` is captured on each busy falling edge. A capture during a frame does not change the bits of that frame. The next frame sends the new word.
- R9: A frame started while busy is high sends the word captured at the previous busy fall.
- R10: While read is high in a frame, `sdout_oe_o` and `sdout_o` are 0, but SCLK still advances the bit position.
- R11: After reset, `sdout_oe_o` and `sdout_o` are 0 and the captured word is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| result_i | input | DATA_W | Conversion result, sampled on busy fall |
| busy_i | input | 1 | High while a conversion runs |
| cs_n_i | input | 1 | Host chip select, active low |
| rd_n_i | input | 1 | Host read strobe, active low |
| sclk_i | input | 1 | Host serial clock |
| ser_sel_i | input | 1 | 1 selects the serial port |
| ext_clk_sel_i | input | 1 | 1 selects the externally supplied clock |
| sdout_o | output | 1 | Serial data, MSB first |
| sdout_oe_o | output | 1 | Data line drive enable |

## Verification
Two conditions are hard to reach from the ports. The first is a busy fall in the middle of a frame, whose new word must wait. The second is a frame whose clock rests high, so its first falling edge must not advance. To reach them, the stimulus places busy pulses between SCLK pulses partway through a frame and picks the resting polarity at random for each frame. Frames cut short, read strobes raised mid-frame and pulses sent after the sixteenth bit are added as directed cases.

// File: rtl/rs_pkg.sv
package rs_pkg;
  // Host-side control lines, grouped so they cross into clk together
  typedef struct packed {
    logic busy;
    logic rd_n;
    logic cs_n;
    logic sclk;
  } rs_ctl_t;

  localparam rs_ctl_t CTL_RESET = '{busy: 1'b0, rd_n: 1'b1, cs_n: 1'b1, sclk: 1'b0};
endpackage

// File: rtl/rs_sync.sv
module rs_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rs_edge.sv
module rs_edge #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_edge
    assign rise[i] = lvl[i] & ~prev_q[i];
    assign fall[i] = ~lvl[i] & prev_q[i];
  end
endmodule

// File: rtl/rs_capture.sv
module rs_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_s,
  input  logic [DATA_W-1:0] result_i,
  output logic [DATA_W-1:0] word_o
);
  logic busy_prev;
  logic busy_fall;

  assign busy_fall = busy_prev & ~busy_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_prev <= 1'b0;
      word_o    <= '0;
    end else begin
      busy_prev <= busy_s;
      if (busy_fall) word_o <= result_i;
    end
  end
endmodule

// File: rtl/rs_shift_core.sv
module rs_shift_core #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_ok,
  input  logic              cs_low,
  input  logic              rd_low,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic [DATA_W-1:0] load_word,
  output logic              sdout_o,
  output logic              oe_o,
  output logic              in_frame_o,
  output logic [CNT_W-1:0]  bit_cnt_o,
  output logic [DATA_W-1:0] shreg_o
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W);

  logic              in_frame;
  logic              armed;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] shreg;
  logic              oe_q;
  logic              advance;

  // A falling edge counts only after a rising edge in this frame
  assign advance = sclk_fall & armed & (bit_cnt != LAST_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      armed    <= 1'b0;
      bit_cnt  <= '0;
      shreg    <= '0;
      oe_q     <= 1'b0;
    end else begin
      oe_q <= mode_ok & cs_low & rd_low;
      if (!mode_ok || cs_rise) begin
        in_frame <= 1'b0;
        armed    <= 1'b0;
      end else if (cs_fall) begin
        in_frame <= 1'b1;
        armed    <= 1'b0;
        bit_cnt  <= '0;
        shreg    <= load_word;
      end else if (in_frame) begin
        if (sclk_rise) armed <= 1'b1;
        if (advance) begin
          shreg   <= {shreg[DATA_W-2:0], 1'b0};
          bit_cnt <= bit_cnt + CNT_W'(1);
        end
      end
    end
  end

  assign sdout_o    = oe_q & in_frame & (bit_cnt != LAST_CNT) & shreg[DATA_W-1];
  assign oe_o       = oe_q;
  assign in_frame_o = in_frame;
  assign bit_cnt_o  = bit_cnt;
  assign shreg_o    = shreg;
endmodule

// File: rtl/serial_result_shifter.sv
module serial_result_shifter #(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] result_i,
  input  logic              busy_i,
  input  logic              cs_n_i,
  input  logic              rd_n_i,
  input  logic              sclk_i,
  input  logic              ser_sel_i,
  input  logic              ext_clk_sel_i,
  output logic              sdout_o,
  output logic              sdout_oe_o
);
  import rs_pkg::*;

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam int CTL_W = $bits(rs_ctl_t);

  rs_ctl_t           ctl_raw;
  rs_ctl_t           ctl_s;
  logic [1:0]        edge_rise;
  logic [1:0]        edge_fall;
  logic [DATA_W-1:0] held_word;
  logic              mode_ok;
  logic              in_frame;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] shreg;

  assign ctl_raw = '{busy: busy_i, rd_n: rd_n_i, cs_n: cs_n_i, sclk: sclk_i};
  assign mode_ok = ser_sel_i & ext_clk_sel_i;

  rs_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_RESET)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s)
  );

  // bit 1: chip select level, bit 0: serial clock level
  rs_edge #(.W(2), .RST_VAL(2'b10)) edge_i (
    .clk(clk), .rst_n(rst_n), .lvl({ctl_s.cs_n, ctl_s.sclk}),
    .rise(edge_rise), .fall(edge_fall)
  );

  rs_capture #(.DATA_W(DATA_W)) cap_i (
    .clk(clk), .rst_n(rst_n), .busy_s(ctl_s.busy),
    .result_i(result_i), .word_o(held_word)
  );

  rs_shift_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) core_i (
    .clk(clk), .rst_n(rst_n), .mode_ok(mode_ok),
    .cs_low(~ctl_s.cs_n), .rd_low(~ctl_s.rd_n),
    .cs_fall(edge_fall[1]), .cs_rise(edge_rise[1]),
    .sclk_rise(edge_rise[0]), .sclk_fall(edge_fall[0]),
    .load_word(held_word), .sdout_o(sdout_o), .oe_o(sdout_oe_o),
    .in_frame_o(in_frame), .bit_cnt_o(bit_cnt), .shreg_o(shreg)
  );
endmodule

// File: rtl/rs_shifter_chk.sv
module rs_shifter_chk #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ser_sel_i,
  input logic              ext_clk_sel_i,
  input logic              sdout_oe_o,
  input logic              in_frame,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [DATA_W-1:0] shreg
);
  assert_oe_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sdout_oe_o |-> $past(ser_sel_i && ext_clk_sel_i));

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(DATA_W));

  assert_cnt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt != $past(bit_cnt)) |-> ((bit_cnt == $past(bit_cnt) + CNT_W'(1)) || (bit_cnt == '0)));

  assert_frame_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && $past(in_frame) && bit_cnt == $past(bit_cnt)) |-> $stable(shreg));

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_frame && !$past(in_frame)) |-> $stable(bit_cnt));
endmodule

bind serial_result_shifter rs_shifter_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ser_sel_i(ser_sel_i), .ext_clk_sel_i(ext_clk_sel_i),
  .sdout_oe_o(sdout_oe_o), .in_frame(in_frame), .bit_cnt(bit_cnt), .shreg(shreg)
);

// File: tb/serial_result_shifter_tb_top.sv
module serial_result_shifter_tb_top;
  localparam int H = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] result_i = '0;
  logic        busy_i = 1'b0;
  logic        cs_n_i = 1'b1;
  logic        rd_n_i = 1'b1;
  logic        sclk_i = 1'b0;
  logic        ser_sel_i = 1'b1;
  logic        ext_clk_sel_i = 1'b1;
  logic        sdout_o;
  logic        sdout_oe_o;

  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;
  logic [15:0] cap_word = '0;

  always #4 clk = ~clk;

  serial_result_shifter dut_i (
    .clk(clk), .rst_n(rst_n), .result_i(result_i), .busy_i(busy_i),
    .cs_n_i(cs_n_i), .rd_n_i(rd_n_i), .sclk_i(sclk_i), .ser_sel_i(ser_sel_i),
    .ext_clk_sel_i(ext_clk_sel_i), .sdout_o(sdout_o), .sdout_oe_o(sdout_oe_o)
  );

  function automatic logic exp_bit(logic [15:0] w, int idx, logic rd_n);
    return rd_n ? 1'b0 : w[15 - idx];
  endfunction

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic busy_pulse(logic [15:0] w);
    result_i = w;
    busy_i = 1'b1;
    waitc(4);
    busy_i = 1'b0;
    cap_word = w;
    waitc(5);
  endtask

  task automatic begin_frame(logic ih, logic [15:0] w, string req);
    sclk_i = ih;
    waitc(H);
    cs_n_i = 1'b0;
    rd_n_i = 1'b0;
    waitc(H);
    chk({req, " first bit"}, sdout_o, w[15]);
    chk({req, " oe on"}, sdout_oe_o, 1'b1);
  endtask

  task automatic pulse(logic ih, logic [15:0] w, int idx, string req);
    if (!ih) begin
      waitc(H);
      chk(req, sdout_o, exp_bit(w, idx, rd_n_i));
      sclk_i = 1'b1; waitc(H); sclk_i = 1'b0;
    end else begin
      sclk_i = 1'b0; waitc(H);
      chk(req, sdout_o, exp_bit(w, idx, rd_n_i));
      sclk_i = 1'b1; waitc(H);
    end
  endtask

  task automatic tail_check(logic ih);
    if (ih) sclk_i = 1'b0;
    waitc(H);
    chk("R7 low after last bit", sdout_o, 1'b0);
    chk("R7 oe held", sdout_oe_o, 1'b1);
    sclk_i = ~sclk_i; waitc(H);
    sclk_i = ~sclk_i; waitc(H);
    chk("R7 low after extra pulse", sdout_o, 1'b0);
  endtask

  task automatic end_frame();
    cs_n_i = 1'b1;
    rd_n_i = 1'b1;
    waitc(H);
    chk("R1 oe off", sdout_oe_o, 1'b0);
    chk("R1 data low", sdout_o, 1'b0);
  endtask

  task automatic full_frame(logic ih, logic [15:0] w, string req);
    begin_frame(ih, w, req);
    for (int i = 0; i < 16; i++) pulse(ih, w, i, req);
    tail_check(ih);
    end_frame();
  endtask

  initial begin
    logic [15:0] w_old;
    logic [15:0] w_new;
    int unsigned seed_v;
    seed_v = $urandom(32'd20240611);
    waitc(5);
    rst_n = 1'b1;
    waitc(3);
    // R11 reset state and zero capture
    chk("R11 oe after reset", sdout_oe_o, 1'b0);
    chk("R11 data after reset", sdout_o, 1'b0);
    full_frame(1'b0, 16'h0000, "R11 zero word");

    // R1 mode gating
    ser_sel_i = 1'b0;
    busy_pulse(16'hFFFF);
    cs_n_i = 1'b0; rd_n_i = 1'b0; waitc(H);
    chk("R1 parallel mode oe", sdout_oe_o, 1'b0);
    chk("R1 parallel mode data", sdout_o, 1'b0);
    cs_n_i = 1'b1; rd_n_i = 1'b1; waitc(H);
    ser_sel_i = 1'b1; ext_clk_sel_i = 1'b0;
    cs_n_i = 1'b0; rd_n_i = 1'b0; waitc(H);
    chk("R1 internal clock oe", sdout_oe_o, 1'b0);
    cs_n_i = 1'b1; rd_n_i = 1'b1; waitc(H);
    ext_clk_sel_i = 1'b1;

    // R2 R3 R4 directed, both resting levels
    busy_pulse(16'hA5C3);
    full_frame(1'b0, 16'hA5C3, "R3 idle low");
    full_frame(1'b1, 16'hA5C3, "R4 idle high");

    // R5 clock edges with chip select high
    for (int k = 0; k < 10; k++) begin sclk_i = ~sclk_i; waitc(H); end
    full_frame(1'b0, 16'hA5C3, "R5 after idle clocks");

    // R6 abort and restart
    busy_pulse(16'h3C81);
    begin_frame(1'b0, 16'h3C81, "R6 abort");
    for (int i = 0; i < 5; i++) pulse(1'b0, 16'h3C81, i, "R6 partial");
    end_frame();
    full_frame(1'b0, 16'h3C81, "R6 restart");

    // R10 read strobe raised mid-frame
    busy_pulse(16'h9F06);
    begin_frame(1'b1, 16'h9F06, "R10 rd");
    for (int i = 0; i < 16; i++) begin
      rd_n_i = (i >= 4 && i < 8);
      if (i == 4) begin
        waitc(H);
        chk("R10 oe off while rd high", sdout_oe_o, 1'b0);
      end
      pulse(1'b1, 16'h9F06, i, "R10 bit");
    end
    rd_n_i = 1'b0;
    tail_check(1'b1);
    end_frame();

    // R8 capture mid-frame, R9 read during conversion
    w_old = cap_word;
    begin_frame(1'b0, w_old, "R8 old");
    for (int i = 0; i < 16; i++) begin
      if (i == 7) busy_pulse(16'h5A17);
      pulse(1'b0, w_old, i, "R8 frame unchanged");
    end
    tail_check(1'b0);
    end_frame();
    full_frame(1'b0, 16'h5A17, "R8 new word");
    busy_i = 1'b1; result_i = 16'h0F0F; waitc(4);
    full_frame(1'b1, 16'h5A17, "R9 during busy");
    busy_i = 1'b0; cap_word = 16'h0F0F; waitc(5);
    full_frame(1'b0, 16'h0F0F, "R9 after busy");

    // Random frames
    for (int f = 0; f < 24; f++) begin
      logic ih;
      int   mid;
      w_new = 16'($urandom);
      ih = 1'($urandom);
      mid = int'($urandom % 20);
      busy_pulse(w_new);
      w_old = cap_word;
      begin_frame(ih, w_old, "R4 random start");
      for (int i = 0; i < 16; i++) begin
        if (i == mid) busy_pulse(16'($urandom));
        pulse(ih, w_old, i, "R3 random bit");
      end
      tail_check(ih);
      end_frame();
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule